// File: doc/BRIEF.md
# Trigger Cycle Monitoring Scaler Bank

This block holds seven free-running 32-bit monitoring counters that watch a trigger decision cycle. It sits next to the cycle sequencer and takes that sequencer's single-tick qualifiers as inputs: the cycle envelope, the waiting-to-distribute flag, the send-decision pulse, the transfer-required level and the busy input. From these it counts cycles, accepts, rejects, plain ticks, ticks inside a cycle, ticks spent waiting, and cycles whose decision was held back by a busy condition.

Software reads each counter as two 16-bit words through a simple strobed register port. Reading the low word also captures that counter's upper half into a per-counter shadow register, so a following read of the high word returns a value that matches the low word already read. A held force-reset register clears counters and keeps them at zero. Each counter has its own bit, and one global bit clears the whole bank.

Top module: `cyc_scaler_bank`

## Requirements
- R1: Counter k (0 cycle, 1 accept, 2 reject, 3 tick, 4 in-cycle, 5 wait, 6 busy-delay) is read at address 20+2k (bits 15:0) and 21+2k (bits 31:16). Reads of addresses not mapped to a register return zero.
- R2: A read of a counter's low word captures that counter's bits 31:16 in the same cycle. A later read of its high word returns the captured value, even if the live counter has moved on since.
- R3: The cycle counter increments once on every clock where the send-decision input is high.
- R4: On a clock with send-decision high, the accept counter increments if transfer-required is high, and otherwise the reject counter increments. Transfer-required alone changes neither counter.
- R5: The tick counter increments on every clock.
- R6: The in-cycle counter increments on every clock where the cycle envelope input is high.
- R7: The wait counter increments on every clock where the waiting input is high.
- R8: The busy-delay counter increments at most once per envelope period. It increments only when busy is high on the first clock of that period on which waiting is high.
- R9: Force register (address 3) bit k, for k from 0 to 6, holds counter k at zero for as long as the bit is set. Once the bit is cleared, the counter counts again starting from zero.
- R10: Force register bit 15 holds all seven counters at zero. The whole force register, including bits 14:7, reads back as written.
- R11: The counters wrap from all ones to zero and never saturate.
- R12: After reset, every counter and the force register are zero, and the read data is zero.
- R13: Read data is registered. It shows the addressed word on the clock after the read strobe and stays unchanged until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_env | input | 1 | Cycle envelope active |
| q_wait | input | 1 | Waiting to distribute decision |
| q_send | input | 1 | Send-decision pulse |
| q_xfer | input | 1 | Transfer-required level |
| q_busy | input | 1 | Busy condition |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |

## Verification
The assertions assume that the qualifiers follow the sequencer's framing. Waiting and send-decision appear only inside an envelope, and the envelope falls between cycles, so the once-per-cycle busy gate is re-armed. They also assume that read and write strobes are single-clock pulses. The directed tasks drive each qualifier from a falling edge for whole clocks and always drop the envelope between cycles. They clear the bank through the global force bit before each scenario, so every expected count is a plain tally of driven clocks.

// File: rtl/cyc_scaler_pkg.sv
`timescale 1ns/1ps
package cyc_scaler_pkg;
  localparam int NUM_CNT   = 7;
  localparam int WORD_W    = 16;
  localparam int BASE_ADDR = 20;
  localparam int FRC_ADDR  = 3;
  localparam int ALL_BIT   = 15;
  localparam int IDX_CYC   = 0;
  localparam int IDX_ACC   = 1;
  localparam int IDX_REJ   = 2;
  localparam int IDX_TICK  = 3;
  localparam int IDX_ENV   = 4;
  localparam int IDX_WAIT  = 5;
  localparam int IDX_BUSY  = 6;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/scaler_cnt.sv
`timescale 1ns/1ps
module scaler_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/busy_first_gate.sv
`timescale 1ns/1ps
module busy_first_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic env,
  input  logic wait_i,
  input  logic busy,
  output logic hit
);
  logic seen_q, seen_d;

  // The first waiting clock of an envelope decides; later clocks are ignored.
  always_comb begin
    hit    = env && wait_i && !seen_q && busy;
    seen_d = env ? (seen_q || wait_i) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= seen_d;
  end
endmodule

// File: rtl/scaler_regs.sv
`timescale 1ns/1ps
module scaler_regs
  import cyc_scaler_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic                            rd_en,
  input  logic [ADDR_W-1:0]               addr,
  input  word_t                           wdata,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_all,
  output logic [NUM_CNT-1:0]              hold,
  output word_t                           rdata
);
  localparam int TOP_ADDR = BASE_ADDR + 2*NUM_CNT;

  word_t                    frc_q, frc_d;
  word_t                    rdata_d;
  logic [NUM_CNT-1:0][15:0] shadow_q, shadow_d;
  logic [NUM_CNT-1:0][15:0] lo_w, hi_w;
  logic [ADDR_W-1:0]        off;
  logic                     in_cnt;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_split
    logic [31:0] ext;
    assign ext     = 32'(cnt_all[i]);
    assign lo_w[i] = ext[15:0];
    assign hi_w[i] = ext[31:16];
    assign hold[i] = frc_q[i] | frc_q[ALL_BIT];
  end

  always_comb begin
    off     = addr - ADDR_W'(BASE_ADDR);
    in_cnt  = (addr >= ADDR_W'(BASE_ADDR)) && (addr < ADDR_W'(TOP_ADDR));
    frc_d    = frc_q;
    shadow_d = shadow_q;
    rdata_d  = rdata;
    if (wr_en && addr == ADDR_W'(FRC_ADDR)) frc_d = wdata;
    if (rd_en) begin
      rdata_d = '0;
      if (addr == ADDR_W'(FRC_ADDR)) rdata_d = frc_q;
      for (int i = 0; i < NUM_CNT; i++) begin
        if (in_cnt && off[ADDR_W-1:1] == (ADDR_W-1)'(i)) begin
          if (!off[0]) begin
            rdata_d     = lo_w[i];
            shadow_d[i] = hi_w[i];
          end else begin
            rdata_d = shadow_q[i];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frc_q    <= '0;
      shadow_q <= '0;
      rdata    <= '0;
    end else begin
      frc_q    <= frc_d;
      shadow_q <= shadow_d;
      rdata    <= rdata_d;
    end
  end
endmodule

// File: rtl/cyc_scaler_bank.sv
`timescale 1ns/1ps
module cyc_scaler_bank
  import cyc_scaler_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_env,
  input  logic              q_wait,
  input  logic              q_send,
  input  logic              q_xfer,
  input  logic              q_busy,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata
);
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all;
  logic [NUM_CNT-1:0]            hold;
  logic [NUM_CNT-1:0]            inc;
  logic                          busy_hit;

  busy_first_gate u_gate (
    .clk(clk), .rst_n(rst_n), .env(q_env), .wait_i(q_wait),
    .busy(q_busy), .hit(busy_hit)
  );

  always_comb begin
    inc           = '0;
    inc[IDX_CYC]  = q_send;
    inc[IDX_ACC]  = q_send && q_xfer;
    inc[IDX_REJ]  = q_send && !q_xfer;
    inc[IDX_TICK] = 1'b1;
    inc[IDX_ENV]  = q_env;
    inc[IDX_WAIT] = q_wait;
    inc[IDX_BUSY] = busy_hit;
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    scaler_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(hold[i]), .inc(inc[i]), .cnt(cnt_all[i])
    );
  end

  scaler_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt_all(cnt_all), .hold(hold), .rdata(rdata)
  );
endmodule

// File: rtl/cyc_scaler_chk.sv
`timescale 1ns/1ps
module cyc_scaler_chk
  import cyc_scaler_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          rd_en,
  input logic [15:0]                   rdata,
  input logic                          q_env,
  input logic                          q_send,
  input logic                          busy_hit,
  input logic [NUM_CNT-1:0]            hold,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all
);
  logic [1:0] hits_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hits_q <= '0;
    else if (!q_env)      hits_q <= '0;
    else if (busy_hit && hits_q != 2'd3) hits_q <= hits_q + 2'd1;
  end

  // R3
  cyc_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_send && !hold[IDX_CYC] |=> cnt_all[IDX_CYC] == $past(cnt_all[IDX_CYC]) + CNT_W'(1));

  // R4
  acc_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_send && !hold[IDX_ACC] && !hold[IDX_REJ] |=>
      ((cnt_all[IDX_ACC] != $past(cnt_all[IDX_ACC])) != (cnt_all[IDX_REJ] != $past(cnt_all[IDX_REJ]))));

  // R5
  tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold[IDX_TICK] |=> cnt_all[IDX_TICK] == $past(cnt_all[IDX_TICK]) + CNT_W'(1));

  // R8
  busy_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_env && hits_q != 2'd0 |-> !busy_hit);

  // R11
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_all[IDX_TICK] == '1 |=> cnt_all[IDX_TICK] == '0);

  // R13
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_hold
    // R9
    force_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold[i] |=> cnt_all[i] == '0);
  end
endmodule

bind cyc_scaler_bank cyc_scaler_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rdata(rdata), .q_env(q_env),
  .q_send(q_send), .busy_hit(busy_hit), .hold(hold), .cnt_all(cnt_all)
);

// File: tb/cyc_scaler_bank_tb_top.sv
`timescale 1ns/1ps
module cyc_scaler_bank_tb_top;
  logic        clk;
  logic        rst_n;
  logic        q_env, q_wait, q_send, q_xfer, q_busy;
  logic        wr_en, rd_en;
  logic [5:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata, rdata_w;
  logic [15:0] last_i, last_w;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 0;

  cyc_scaler_bank dut_i (
    .clk(clk), .rst_n(rst_n), .q_env(q_env), .q_wait(q_wait), .q_send(q_send),
    .q_xfer(q_xfer), .q_busy(q_busy), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  cyc_scaler_bank #(.CNT_W(8)) dut_w (
    .clk(clk), .rst_n(rst_n), .q_env(q_env), .q_wait(q_wait), .q_send(q_send),
    .q_xfer(q_xfer), .q_busy(q_busy), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata_w)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [5:0] a);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    last_i = rdata; last_w = rdata_w;
  endtask

  task automatic clear_all();
    wr(6'd3, 16'h8000);
    wr(6'd3, 16'h0000);
  endtask

  task automatic pulse_send(logic x);
    q_xfer = x; q_send = 1'b1;
    @(negedge clk);
    q_send = 1'b0; q_xfer = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R12 rdata", rdata, 0);
    rd(6'd22); chk("R12 accept", last_i, 0);
    rd(6'd3);  chk("R12 force reg", last_i, 0);
    rd(6'd32); chk("R12 busy-delay", last_i, 0);
  endtask

  task automatic t_tick();
    clear_all();
    idle(37);
    rd(6'd26); chk("R5 tick low", last_i, 37);
    rd(6'd27); chk("R5 tick high", last_i, 0);
  endtask

  task automatic t_decisions();
    clear_all();
    pulse_send(1'b1);
    pulse_send(1'b0);
    pulse_send(1'b1);
    q_xfer = 1'b1; idle(3); q_xfer = 1'b0;   // transfer-required alone
    rd(6'd20); chk("R3 cycles", last_i, 3);
    rd(6'd22); chk("R4 accepts", last_i, 2);
    rd(6'd24); chk("R4 rejects", last_i, 1);
  endtask

  task automatic t_env_wait();
    clear_all();
    q_env = 1'b1; idle(3);
    q_wait = 1'b1; idle(4); q_wait = 1'b0;
    idle(3); q_env = 1'b0; idle(2);
    rd(6'd28); chk("R6 in-cycle", last_i, 10);
    rd(6'd30); chk("R7 wait", last_i, 4);
  endtask

  task automatic t_busy();
    clear_all();
    // cycle A: busy on first wait clock, several busy clocks
    q_env = 1'b1; idle(2);
    q_wait = 1'b1; q_busy = 1'b1; idle(3);
    q_wait = 1'b0; q_busy = 1'b0; q_env = 1'b0; idle(2);
    // cycle B: not busy on first wait clock, busy later
    q_env = 1'b1; idle(1);
    q_wait = 1'b1; idle(1); q_busy = 1'b1; idle(2);
    q_wait = 1'b0; q_busy = 1'b0; q_env = 1'b0; idle(2);
    // cycle C: busy on the single wait clock, then busy without waiting
    q_env = 1'b1; idle(1);
    q_wait = 1'b1; q_busy = 1'b1; idle(1);
    q_wait = 1'b0; idle(2);
    q_busy = 1'b0; q_env = 1'b0; idle(2);
    rd(6'd32); chk("R8 busy-delay", last_i, 2);
    rd(6'd30); chk("R7 wait mixed", last_i, 7);
  endtask

  task automatic t_force_single();
    clear_all();
    wr(6'd3, 16'h0002);
    pulse_send(1'b1);
    pulse_send(1'b1);
    rd(6'd22); chk("R9 held accept", last_i, 0);
    rd(6'd20); chk("R9 other counter runs", last_i, 2);
    wr(6'd3, 16'h0000);
    pulse_send(1'b1);
    rd(6'd22); chk("R9 released accept", last_i, 1);
  endtask

  task automatic t_force_all();
    clear_all();
    wr(6'd3, 16'h8000);
    pulse_send(1'b0);
    q_env = 1'b1; idle(4); q_env = 1'b0;
    rd(6'd26); chk("R10 tick held", last_i, 0);
    rd(6'd24); chk("R10 reject held", last_i, 0);
    rd(6'd28); chk("R10 in-cycle held", last_i, 0);
    wr(6'd3, 16'h5A80);
    rd(6'd3);  chk("R10 readback", last_i, 16'h5A80);
    wr(6'd3, 16'h0000);
  endtask

  task automatic t_map_latency();
    rd(6'd0);  chk("R1 unmapped 0", last_i, 0);
    rd(6'd40); chk("R1 unmapped 40", last_i, 0);
    clear_all();
    idle(5);
    rd(6'd26); chk("R1 tick low addr", last_i, 5);
    idle(3);
    chk("R13 held rdata", rdata, 5);
  endtask

  task automatic t_coherent();
    clear_all();
    idle(65530);
    rd(6'd26); chk("R2 low", last_i, 65530);
    idle(20);
    rd(6'd27); chk("R2 captured high", last_i, 0);
    rd(6'd26); chk("R2 low after carry", last_i, 16);
    rd(6'd27); chk("R2 high after carry", last_i, 1);
  endtask

  task automatic t_wrap();
    clear_all();
    idle(300);
    rd(6'd26);
    chk("R11 narrow wraps", last_w, 300 % 256);
    chk("R11 wide counts", last_i, 300);
  endtask

  initial begin
    rst_n = 1'b0;
    {q_env, q_wait, q_send, q_xfer, q_busy} = '0;
    wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    last_i = '0; last_w = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_tick();
    t_decisions();
    t_env_wait();
    t_busy();
    t_force_single();
    t_force_all();
    t_map_latency();
    t_wrap();
    t_coherent();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule